// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Queue

This block is a single-clock first-in, first-out queue. Words presented on `din` with `push` high are stored in a simple dual-port RAM whose read port is registered. Words leave in the order they arrived when `pop` is high. Flags and an occupancy count report the fill state. Two registered pulse outputs flag a push refused because the queue is full and a pop refused because the queue is empty. When `push` and `pop` are both high in one cycle, the pop is taken first. A full queue can therefore still take the new word.

A parameter selects one of two read styles. In the classic style a pop makes the oldest word appear on `dout` one cycle later, and `dout` then holds that word until the next accepted pop. In the look-ahead style the oldest stored word already sits on `dout` before anyone pops, and a pop moves on to the next word. This style keeps up to three words in a small register stage beside the RAM, so its capacity is three words larger than the depth parameter.

A local synchronous clear empties the queue's bookkeeping without erasing the RAM.

Top module: `dm_fifo`

## Requirements
- R1: A push that is accepted raises `level` by 1, and `empty` goes low, in the cycle after `push` is sampled. Accepted pops lower `level` by 1 on the same schedule.
- R2: In classic mode (`FWFT_MODE`=0), an accepted pop sampled in one cycle puts the oldest stored word on `dout` in the next cycle.
- R3: In classic mode, `dout` does not change on cycles without an accepted pop. This covers push-only cycles, refused pops and idle cycles.
- R4: Capacity is `DEPTH` in classic mode and `DEPTH`+3 in look-ahead mode. `DEPTH` must be at least 4 and defaults to 10. `empty` is 1 exactly when `level` is 0. `full` is 1 exactly when `level` equals the capacity.
- R5: With `push` and `pop` both high, the pop is taken first. On a full queue both are accepted and `level` stays at the capacity. On an empty queue the pop is refused and the pushed word is stored.
- R6: A push while `full` without a pop changes neither the contents nor `level`. `overflow` is 1 for exactly the following cycle.
- R7: A pop while `empty` changes neither the contents nor `level`. `underflow` is 1 for exactly the following cycle.
- R8: In look-ahead mode (`FWFT_MODE`=1), whenever `level` is non-zero, `dout` shows the oldest stored word with no pop request. This includes the cycle in which a first word becomes visible in `level`. An accepted pop moves `dout` to the next word one cycle later.
- R9: `soft_clr` high at a clock edge sets `level` to 0, `empty` to 1, and `full`, `overflow` and `underflow` to 0 from the next cycle. It overrides `push` and `pop` in that cycle. In classic mode it leaves `dout` unchanged. Words pushed afterwards come back in order.
- R10: `rst_n` low at a clock edge sets `level` to 0, `empty` to 1, `full`, `overflow` and `underflow` to 0, and the classic-mode `dout` to 0.
- R11: Word order is kept across any number of RAM pointer wrap-arounds under any mix of push, pop and clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_clr | input | 1 | Synchronous local clear of count, flags and pointers, active high |
| push | input | 1 | Store `din` at the tail |
| pop | input | 1 | Remove the head word |
| din | input | DATA_W | Word to store |
| dout | output | DATA_W | Read word (classic) or current head word (look-ahead) |
| empty | output | 1 | Queue holds no words |
| full | output | 1 | Queue holds as many words as its capacity |
| level | output | $clog2(DEPTH+4) | Number of stored words |
| overflow | output | 1 | One-cycle pulse after a refused push |
| underflow | output | 1 | One-cycle pulse after a refused pop |

## Verification
The embedded assertions check the following on every cycle:
- flag and count consistency, and the count bound;
- the one-step count arithmetic;
- the refusal pulses and the clear;
- that the RAM read register holds while no read is issued;
- in look-ahead mode, that the output stage is never empty while words are stored and that count equals the words split across RAM, in-flight read and stage.

Data order and values can only be shown by the bench. It runs a classic and a look-ahead instance side by side against queue models. Its directed scenarios cover full and empty boundaries, simultaneous push and pop at both ends, and clears with data present. A long random run with fill-heavy, drain-heavy and balanced phases wraps the pointers many times.

// File: rtl/dm_fifo_pkg.sv
// Package: shared constants and helpers for the dual-mode FIFO.
// Assumes: the look-ahead output stage never holds more than three words.
package dm_fifo_pkg;

    // Number of words in the look-ahead output stage.
    localparam int unsigned STAGE_SLOTS = 3;

    // Add two slot indices modulo STAGE_SLOTS; a is 0..2, b is 0..3.
    function automatic logic [1:0] slot_add(input logic [1:0] a, input logic [1:0] b);
        logic [2:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 3'(STAGE_SLOTS)) begin
            s = s - 3'(STAGE_SLOTS);
        end
        return s[1:0];
    endfunction

endpackage

// File: rtl/dm_fifo_ram.sv
// Module: simple dual-port RAM with one write port and one registered read port.
// Assumes: a read and a write to the same address in one cycle return the
// old word (the read samples before the write lands). Storage is never reset;
// only the read register is.
module dm_fifo_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 10,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port: store a word when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: capture a word on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

    // R3: the read register holds while no read is issued.
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));

endmodule

// File: rtl/dm_fifo_ptr.sv
// Module: address pointer that steps by one and wraps at DEPTH-1.
// Assumes: clr takes priority over inc; both are synchronous.
module dm_fifo_ptr #(
    parameter int DEPTH = 10,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] ptr
);

    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    // Advance with wrap-around, or return to zero on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr <= '0;
        end else if (inc) begin
            ptr <= (ptr == LAST) ? '0 : ptr + AW'(1);
        end
    end

    // R11: the pointer never leaves the RAM address range.
    a_r11_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST);

endmodule

// File: rtl/dm_fifo_status.sv
// Module: occupancy counter, flags and refusal pulses.
// Decides which pushes and pops are accepted: the pop is judged first, so a
// full queue accepts a push in a cycle where a pop is also accepted.
// Assumes: CAP fits in CNT_W bits; clr is synchronous and overrides all.
module dm_fifo_status #(
    parameter int CAP   = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [CNT_W-1:0] level,
    output logic             empty,
    output logic             full,
    output logic             overflow,
    output logic             underflow
);

    localparam logic [CNT_W-1:0] CAP_L = CNT_W'(CAP);

    logic [CNT_W-1:0] level_nx;

    // Acceptance: pop first, then push if room remains.
    always_comb begin
        pop_ok   = pop && !empty && !clr;
        push_ok  = push && !clr && (!full || pop_ok);
        level_nx = level + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    // Count, flags and one-cycle refusal pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            level     <= '0;
            empty     <= 1'b1;
            full      <= 1'b0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            level     <= level_nx;
            empty     <= (level_nx == '0);
            full      <= (level_nx == CAP_L);
            overflow  <= push && full && !pop_ok;
            underflow <= pop && empty;
        end
    end

    // R4: flags agree with the count; the count stays within capacity.
    a_r4_empty_flag: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0));
    a_r4_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level == CAP_L));
    a_r4_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CAP_L);
    // R1: a lone accepted push adds one word.
    a_r1_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && !pop_ok) |=> (level == $past(level) + CNT_W'(1)));
    // R5: accepted push and pop together keep the count.
    a_r5_both_count: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> $stable(level));
    // R6: a refused push pulses overflow and keeps the count.
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (overflow && $stable(level)));
    // R7: a refused pop pulses underflow and keeps the count at zero.
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clr) |=> (underflow && level == '0));
    // R9: a clear empties the queue on the next cycle.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0 && empty && !full && !overflow && !underflow));

endmodule

// File: rtl/dm_fifo_stage.sv
// Module: three-word look-ahead output stage, a small circular queue.
// Up to two words may enter per cycle: first the word returning from the RAM
// read port, then a word pushed straight from the input. The head word is
// always on head_data.
// Assumes: the caller never overfills it and never takes from it when empty.
module dm_fifo_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              arrive,
    input  logic [DATA_W-1:0] arrive_data,
    input  logic              bypass,
    input  logic [DATA_W-1:0] bypass_data,
    input  logic              take,
    output logic [DATA_W-1:0] head_data,
    output logic [1:0]        fill
);
    import dm_fifo_pkg::*;

    logic [DATA_W-1:0] slot [STAGE_SLOTS];
    logic [1:0]        hd;
    logic [1:0]        tail;
    logic [1:0]        tail2;

    // Positions where the returning and the bypassed words go.
    always_comb begin
        tail  = slot_add(hd, fill);
        tail2 = slot_add(tail, 2'(arrive));
    end

    // One register per slot; a slot takes at most one word per cycle.
    for (genvar g = 0; g < STAGE_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (arrive && tail == 2'(g)) begin
                slot[g] <= arrive_data;
            end else if (bypass && tail2 == 2'(g)) begin
                slot[g] <= bypass_data;
            end
        end
    end

    // Head index and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hd   <= '0;
            fill <= '0;
        end else begin
            hd   <= take ? slot_add(hd, 2'd1) : hd;
            fill <= fill + 2'(arrive) + 2'(bypass) - 2'(take);
        end
    end

    assign head_data = slot[hd];

    // R8: the stage is never overfilled and never read when empty.
    a_r8_stage_room: assert property (@(posedge clk) disable iff (!rst_n || clr)
        ({1'b0, fill} + 3'(arrive) + 3'(bypass)) <= (3'(STAGE_SLOTS) + 3'(take)));
    a_r8_stage_take: assert property (@(posedge clk) disable iff (!rst_n || clr)
        take |-> (fill != 2'd0));

endmodule

// File: rtl/dm_fifo.sv
// Module: dual-mode synchronous FIFO (top).
// FWFT_MODE=0: words live only in the RAM, and dout is the RAM read register.
// FWFT_MODE=1: a three-word output stage holds the head. The RAM refills the
// stage through its registered read port, and pushes go straight to the stage
// while the RAM is empty. Capacity is DEPTH+3.
// Assumes: DEPTH >= 4; one clock; rst_n and soft_clr are synchronous.
module dm_fifo #(
    parameter int DATA_W    = 16,
    parameter int DEPTH     = 10,
    parameter bit FWFT_MODE = 1'b0,
    localparam int CNT_W    = $clog2(DEPTH + 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              empty,
    output logic              full,
    output logic [CNT_W-1:0]  level,
    output logic              overflow,
    output logic              underflow
);

    localparam int AW  = $clog2(DEPTH);
    localparam int CAP = DEPTH + (FWFT_MODE ? 3 : 0);
    localparam int RCW = AW + 1;

    logic              push_ok;
    logic              pop_ok;
    logic              ram_we;
    logic              ram_re;
    logic [AW-1:0]     wptr;
    logic [AW-1:0]     rptr;
    logic [DATA_W-1:0] ram_q;

    dm_fifo_status #(.CAP(CAP), .CNT_W(CNT_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_clr),
        .push     (push),
        .pop      (pop),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .level    (level),
        .empty    (empty),
        .full     (full),
        .overflow (overflow),
        .underflow(underflow)
    );

    dm_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (ram_we),
        .waddr(wptr),
        .wdata(din),
        .re   (ram_re),
        .raddr(rptr),
        .rdata(ram_q)
    );

    dm_fifo_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_clr),
        .inc  (ram_we),
        .ptr  (wptr)
    );

    dm_fifo_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (soft_clr),
        .inc  (ram_re),
        .ptr  (rptr)
    );

    if (!FWFT_MODE) begin : g_classic
        // Classic: every accepted word goes through the RAM; dout is the read register.
        always_comb begin
            ram_we = push_ok;
            ram_re = pop_ok;
            dout   = ram_q;
        end

        // R2: an accepted pop always issues a RAM read.
        a_r2_pop_reads: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && !empty && !soft_clr) |-> ram_re);
    end else begin : g_fwft
        logic [RCW-1:0]    ram_cnt;
        logic              inflight;
        logic [1:0]        st_fill;
        logic [2:0]        room_used;
        logic              bypass;
        logic [DATA_W-1:0] st_head;

        // Refill and bypass decisions for the output stage.
        always_comb begin
            room_used = {1'b0, st_fill} + 3'(inflight) - 3'(pop_ok);
            ram_re    = (ram_cnt != '0) && (room_used < 3'd3) && !soft_clr;
            bypass    = push_ok && (ram_cnt == '0) && (room_used < 3'd3);
            ram_we    = push_ok && !bypass;
            dout      = st_head;
        end

        // Words held in RAM and the one-cycle read in flight.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_clr) begin
                ram_cnt  <= '0;
                inflight <= 1'b0;
            end else begin
                ram_cnt  <= ram_cnt + RCW'(ram_we) - RCW'(ram_re);
                inflight <= ram_re;
            end
        end

        dm_fifo_stage #(.DATA_W(DATA_W)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .clr        (soft_clr),
            .arrive     (inflight),
            .arrive_data(ram_q),
            .bypass     (bypass),
            .bypass_data(din),
            .take       (pop_ok),
            .head_data  (st_head),
            .fill       (st_fill)
        );

        // R8: a stored word is always present at the output stage.
        a_r8_head_ready: assert property (@(posedge clk) disable iff (!rst_n)
            (level != '0) |-> (st_fill != 2'd0));
        // R4: the count equals the words spread over RAM, read path and stage.
        a_r4_level_split: assert property (@(posedge clk) disable iff (!rst_n)
            32'(level) == 32'(ram_cnt) + 32'(inflight) + 32'(st_fill));
        a_r4_ram_bound: assert property (@(posedge clk) disable iff (!rst_n)
            ram_cnt <= RCW'(DEPTH));
    end

endmodule

// File: tb/tb_dm_fifo.sv
// Bench: one classic and one look-ahead instance get the same stimulus and are
// compared each cycle against queue models kept in the bench.
module tb_dm_fifo;

    localparam int DW    = 16;
    localparam int DEP   = 10;
    localparam int CW    = $clog2(DEP + 4);
    localparam int CAP_C = DEP;
    localparam int CAP_F = DEP + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_clr = 1'b0;
    logic          push = 1'b0;
    logic          pop = 1'b0;
    logic [DW-1:0] din = '0;

    logic [DW-1:0] dout_c, dout_f;
    logic          empty_c, empty_f, full_c, full_f;
    logic [CW-1:0] level_c, level_f;
    logic          ovf_c, ovf_f, unf_c, unf_f;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [DW-1:0] mq_c[$];
    logic [DW-1:0] mq_f[$];
    logic [DW-1:0] ed_c = '0;
    bit eo_c, eu_c, eo_f, eu_f;
    bit last_pk_c;
    bit in_random;

    always #4 clk = ~clk;

    dm_fifo #(.DATA_W(DW), .DEPTH(DEP), .FWFT_MODE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .push(push), .pop(pop),
        .din(din), .dout(dout_c), .empty(empty_c), .full(full_c),
        .level(level_c), .overflow(ovf_c), .underflow(unf_c)
    );

    dm_fifo #(.DATA_W(DW), .DEPTH(DEP), .FWFT_MODE(1'b1)) dut_fw (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .push(push), .pop(pop),
        .din(din), .dout(dout_f), .empty(empty_f), .full(full_f),
        .level(level_f), .overflow(ovf_f), .underflow(unf_f)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare both instances with the models (called away from the clock edge).
    task automatic compare(input string ltag);
        chk(ltag, "classic level", 32'(level_c), 32'(mq_c.size()));
        chk(ltag, "fwft level", 32'(level_f), 32'(mq_f.size()));
        chk("R4", "classic empty", 32'(empty_c), 32'(mq_c.size() == 0));
        chk("R4", "classic full", 32'(full_c), 32'(mq_c.size() == CAP_C));
        chk("R4", "fwft empty", 32'(empty_f), 32'(mq_f.size() == 0));
        chk("R4", "fwft full", 32'(full_f), 32'(mq_f.size() == CAP_F));
        chk("R6", "classic overflow", 32'(ovf_c), 32'(eo_c));
        chk("R6", "fwft overflow", 32'(ovf_f), 32'(eo_f));
        chk("R7", "classic underflow", 32'(unf_c), 32'(eu_c));
        chk("R7", "fwft underflow", 32'(unf_f), 32'(eu_f));
        chk(in_random ? "R11" : (last_pk_c ? "R2" : "R3"), "classic dout",
            32'(dout_c), 32'(ed_c));
        if (mq_f.size() > 0) begin
            chk(in_random ? "R11" : "R8", "fwft dout", 32'(dout_f), 32'(mq_f[0]));
        end
    endtask

    // Drive one cycle of stimulus, advance the models, then compare.
    task automatic step(input bit p, input bit o, input bit c);
        logic [DW-1:0] d;
        bit pk, pu;
        string ltag;
        d = DW'($urandom);
        push = p; pop = o; soft_clr = c; din = d;
        ltag = c ? "R9" : ((p && o) ? "R5" : "R1");
        last_pk_c = 1'b0;
        if (c) begin
            mq_c.delete(); mq_f.delete();
            eo_c = 0; eu_c = 0; eo_f = 0; eu_f = 0;
        end else begin
            pk = o && (mq_c.size() > 0);
            pu = p && ((mq_c.size() < CAP_C) || pk);
            eu_c = o && (mq_c.size() == 0);
            eo_c = p && !pu;
            if (pk) begin
                ed_c = mq_c.pop_front();
                last_pk_c = 1'b1;
            end
            if (pu) mq_c.push_back(d);
            pk = o && (mq_f.size() > 0);
            pu = p && ((mq_f.size() < CAP_F) || pk);
            eu_f = o && (mq_f.size() == 0);
            eo_f = p && !pu;
            if (pk) void'(mq_f.pop_front());
            if (pu) mq_f.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        compare(ltag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] held;
        in_random = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state.
        chk("R10", "classic level", 32'(level_c), 0);
        chk("R10", "classic empty", 32'(empty_c), 1);
        chk("R10", "classic full", 32'(full_c), 0);
        chk("R10", "classic dout", 32'(dout_c), 0);
        chk("R10", "fwft level", 32'(level_f), 0);
        chk("R10", "fwft empty", 32'(empty_f), 1);
        chk("R10", "pulses", 32'({ovf_c, unf_c, ovf_f, unf_f}), 0);
        rst_n = 1'b1;

        // R7: pop on empty; R5: push and pop on empty.
        step(0, 1, 0);
        step(0, 0, 0);
        step(1, 1, 0);
        // R1/R3: fill the classic instance; dout must stay put.
        for (int i = 0; i < CAP_C - 1; i++) step(1, 0, 0);
        // R6 for classic while the look-ahead one fills to DEPTH+3.
        for (int i = 0; i < 3; i++) step(1, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0);
        // R5: push and pop together on two full queues.
        step(1, 1, 0);
        step(1, 1, 0);
        // R2/R8: drain past empty.
        for (int i = 0; i < CAP_F + 2; i++) step(0, 1, 0);
        // R9: clear with data present, overriding push and pop.
        for (int i = 0; i < 5; i++) step(1, 0, 0);
        step(0, 1, 0);
        held = dout_c;
        step(1, 1, 1);
        chk("R9", "classic dout kept", 32'(dout_c), 32'(held));
        step(0, 1, 0);
        for (int i = 0; i < 4; i++) step(1, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 1, 0);

        // R11: random run with fill, drain and balanced phases.
        in_random = 1'b1;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            int ph, pp, po;
            ph = (i / 200) % 3;
            pp = (ph == 0) ? 75 : ((ph == 1) ? 25 : 50);
            po = (ph == 0) ? 25 : ((ph == 1) ? 75 : 50);
            step(($urandom % 100) < pp, ($urandom % 100) < po, ($urandom % 300) == 0);
        end
        in_random = 1'b0;
        for (int i = 0; i < CAP_F + 1; i++) step(0, 1, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule